// File: doc/BRIEF.md
# Double-Buffered Timekeeping Register Window

This block is the bus-facing front end of a byte-wide 8K x 8 timekeeping memory. It decodes a 13-bit address, sends every access below the top eight locations to an external RAM, and serves those eight locations itself. Slot 0 is a control byte. Slots 1 to 7 show seconds, minutes, hours, day-of-week, date, month and year in BCD. A separate calendar counter keeps the running time and supplies it on `live_time`. It accepts a new time on `load_time` when `load_stb` pulses.

The time bytes are double-buffered. Setting the freeze bit captures the running time into holding registers while the counter keeps counting. Setting the set bit captures the time in the same way and also lets software overwrite the held values. Clearing the set bit commits the held values to the counter. Register bits that carry no time field are kept here as plain storage. Two of these bits drive the oscillator-stop and frequency-test outputs.

The bus is synchronous. A write takes effect on the clock edge where `bus_we` is high. Read data for the address presented at an edge appears on `bus_rdata` after that edge.

Top module: `rtcw_window`

## Requirements
- R1: Addresses 0x1FF8 to 0x1FFF belong to the window, in slot order: control, seconds, minutes, hours, day, date, month, year. For these addresses `ram_we` stays low. Every lower address drives `ram_we` equal to `bus_we`, with `ram_addr` and `ram_wdata` copied from the bus. Its `bus_rdata` is the value on `ram_rdata` one cycle after the address was presented.
- R2: After reset the control byte reads 0x00, seconds bit 7 reads 1, `osc_stop` is 1, `freq_test` is 0 and `load_stb` is 0.
- R3: While control bits 7 and 6 are both 0, a read of a time slot returns the live counter's field bits merged with the slot's stored bits.
- R4: A control write that sets bit 6 (freeze) from the unfrozen state captures the live time. Later reads return the captured values while `live_time` changes.
- R5: Clearing the freeze bit while the set bit is 0 makes all time slots show the live time again, from the next read.
- R6: A control write that sets bit 7 (set) freezes the time slots in the same way. While the set bit is 1, writes to a time slot replace all 8 of its bits, and the new value reads back.
- R7: A control write that clears the set bit raises `load_stb` for exactly one cycle, the cycle after that write. During that cycle `load_time` carries the held field bits, with all other bits at 0.
- R8: While the set bit is 0, writes to the field bits of a time slot are ignored: the readback still follows the live or captured time, and no load occurs.
- R9: When both control bits are 1, the set bit takes precedence. Clearing only the set bit still commits the held values, and the reads stay frozen at the committed values while the freeze bit stays 1.
- R10: Non-field bits are stored and read back in every mode. This includes control bits 5:0, which have no effect on freezing, loading or the outputs.
- R11: `osc_stop` follows seconds bit 7 and `freq_test` follows day bit 6. A write to either bit reaches the output on the edge of the write, in any mode.
- R12: Field bits per slot are: seconds 6:0, minutes 6:0, hours 5:0, day 2:0, date 5:0, month 4:0, year 7:0. In `live_time` and `load_time`, byte k holds slot k+1, so the seconds byte is bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for the address of the previous cycle |
| ram_we | output | 1 | Write strobe to the external RAM |
| ram_addr | output | 13 | Address to the external RAM |
| ram_wdata | output | 8 | Write data to the external RAM |
| ram_rdata | input | 8 | Synchronous read data from the external RAM |
| live_time | input | 56 | Running time from the calendar counter, seven bytes |
| load_stb | output | 1 | One-cycle strobe to load the counter |
| load_time | output | 56 | Time to load, field bits only |
| osc_stop | output | 1 | Oscillator stop request |
| freq_test | output | 1 | Frequency test request |

## Verification
The results fall due at three different times.
- `ram_we` follows the bus in the same cycle, so the bench samples it 1 ns after it drives a write.
- Read data, the halt bits, the stored bits and the two control outputs all change on the edge that takes the access. Reads are therefore checked at the falling edge after the address was set up.
- `load_stb` is registered from the committing write. It is checked at the falling edge after that write, and then again one cycle later, where it must have dropped.

The bench changes `live_time` and every bus input only on falling edges. This keeps the value captured by a freeze fixed and known to the reference model.

// File: rtl/rtcw_pkg.sv
// Package rtcw_pkg
// Shared constants, types and the per-slot field masks of the timekeeping
// register window. Byte k of a time vector holds window slot k+1.
package rtcw_pkg;

    localparam int BYTE_W      = 8;
    localparam int NUM_TIME    = 7;
    localparam int NUM_SLOT    = NUM_TIME + 1;
    localparam int SLOT_W      = $clog2(NUM_SLOT);
    localparam int SPARE_W     = BYTE_W - 2;
    localparam int TIME_W      = NUM_TIME * BYTE_W;

    localparam int SET_BIT     = 7;   // control: stage and commit a new time
    localparam int FRZ_BIT     = 6;   // control: freeze the visible time
    localparam int OSC_BIT     = 7;   // seconds byte: oscillator stop
    localparam int FTEST_BIT   = 6;   // day byte: frequency test
    localparam int SEC_POS     = 0;
    localparam int DAY_POS     = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NUM_TIME-1:0][BYTE_W-1:0] time_vec_t;

    // Bits of each time byte that belong to the running counter.
    function automatic byte_t field_mask(input int pos);
        case (pos)
            0:       return 8'h7F;  // seconds
            1:       return 8'h7F;  // minutes
            2:       return 8'h3F;  // hours
            3:       return 8'h07;  // day of week
            4:       return 8'h3F;  // date
            5:       return 8'h1F;  // month
            default: return 8'hFF;  // year
        endcase
    endfunction

endpackage

// File: rtl/rtcw_decode.sv
// Module rtcw_decode
// Splits the byte address space between the top register window and the
// external RAM. It assumes the window is aligned to its own size at the
// top of the space. It is purely combinational.
module rtcw_decode
    import rtcw_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              win_hit,
    output logic [SLOT_W-1:0] slot,
    output logic              ram_we
);

    localparam int unsigned     BASE_INT = (1 << ADDR_W) - NUM_SLOT;
    localparam logic [ADDR_W-1:0] WIN_BASE = BASE_INT[ADDR_W-1:0];

    // Window hit, slot number and RAM write gating.
    always_comb begin
        win_hit = (addr >= WIN_BASE);
        slot    = addr[SLOT_W-1:0];
        ram_we  = we & ~win_hit;
    end

endmodule

// File: rtl/rtcw_ctrl.sv
// Module rtcw_ctrl
// Holds the control byte: the set and freeze bits plus six spare bits.
// It flags the write that enters the halted state, which triggers a
// capture, and the write that clears the set bit, which triggers a commit.
// It registers the commit as a one-cycle load strobe. It assumes at most
// one control write per cycle.
module rtcw_ctrl
    import rtcw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  byte_t              wdata,
    output logic               set_q,
    output logic               frz_q,
    output logic [SPARE_W-1:0] spare_q,
    output logic               halted,
    output logic               capture,
    output logic               commit,
    output logic               load_stb
);

    logic load_q;

    // Decode the capture and commit events of the present write.
    always_comb begin
        halted  = set_q | frz_q;
        capture = ctrl_we & ~halted & (wdata[SET_BIT] | wdata[FRZ_BIT]);
        commit  = ctrl_we & set_q & ~wdata[SET_BIT];
    end

    // Control byte storage and the registered load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q   <= 1'b0;
            frz_q   <= 1'b0;
            spare_q <= '0;
            load_q  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                set_q   <= wdata[SET_BIT];
                frz_q   <= wdata[FRZ_BIT];
                spare_q <= wdata[SPARE_W-1:0];
            end
            load_q <= commit;
        end
    end

    assign load_stb = load_q;

endmodule

// File: rtl/rtcw_hold.sv
// Module rtcw_hold
// Keeps one holding byte per time slot. The field bits take the captured
// or staged time. The other bits are plain storage, including the
// oscillator-stop and frequency-test bits. It produces the visible bytes
// and the field-only values handed to the counter on a commit. It assumes
// that capture and a slot write never coincide.
module rtcw_hold
    import rtcw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  time_vec_t           live,
    input  logic                halted,
    input  logic                set_mode,
    input  logic                capture,
    input  logic [NUM_TIME-1:0] byte_wr,
    input  byte_t               wdata,
    output time_vec_t           shown,
    output time_vec_t           staged,
    output time_vec_t           hold_o,
    output logic                osc_stop,
    output logic                freq_test
);

    generate
        for (genvar g = 0; g < NUM_TIME; g++) begin : g_slot
            localparam byte_t FMASK = field_mask(g);
            localparam byte_t RST_V = (g == SEC_POS) ? byte_t'(1 << OSC_BIT) : '0;
            byte_t q;

            // Capture the live field bits, or take a bus write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= RST_V;
                end else if (capture) begin
                    q <= (live[g] & FMASK) | (q & ~FMASK);
                end else if (byte_wr[g]) begin
                    q <= set_mode ? wdata : ((q & FMASK) | (wdata & ~FMASK));
                end
            end

            // Visible byte: held value when halted, otherwise the live fields.
            assign shown[g]  = halted ? q : ((live[g] & FMASK) | (q & ~FMASK));
            assign staged[g] = q & FMASK;
            assign hold_o[g] = q;
        end
    endgenerate

    assign osc_stop  = hold_o[SEC_POS][OSC_BIT];
    assign freq_test = hold_o[DAY_POS][FTEST_BIT];

endmodule

// File: rtl/rtcw_window.sv
// Module rtcw_window
// Top of the double-buffered timekeeping register window. It decodes the
// address and passes RAM accesses through. It serves the control and time
// slots, muxes read data with one cycle of latency and drives the counter
// load interface. It assumes that the external RAM returns read data one
// cycle after the address.
module rtcw_window
    import rtcw_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    input  logic [55:0]       live_time,
    output logic              load_stb,
    output logic [55:0]       load_time,
    output logic              osc_stop,
    output logic              freq_test
);

    logic                win_hit;
    logic [SLOT_W-1:0]   slot;
    logic                ctrl_we;
    logic [NUM_TIME-1:0] byte_wr;
    logic                set_q, frz_q, halted, capture, commit;
    logic [SPARE_W-1:0]  spare_q;
    time_vec_t           live_v, shown, staged, hold_o;
    logic [TIME_W-1:0]   hold_flat;
    byte_t               win_byte, rd_q;
    logic                sel_q;

    assign live_v    = live_time;
    assign hold_flat = hold_o;

    rtcw_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .we      (bus_we),
        .win_hit (win_hit),
        .slot    (slot),
        .ram_we  (ram_we)
    );

    // Per-slot write enables inside the window.
    always_comb begin
        ctrl_we = bus_we & win_hit & (slot == '0);
        for (int k = 0; k < NUM_TIME; k++) begin
            byte_wr[k] = bus_we & win_hit & (slot == SLOT_W'(k + 1));
        end
    end

    rtcw_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .wdata    (bus_wdata),
        .set_q    (set_q),
        .frz_q    (frz_q),
        .spare_q  (spare_q),
        .halted   (halted),
        .capture  (capture),
        .commit   (commit),
        .load_stb (load_stb)
    );

    rtcw_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live_v),
        .halted    (halted),
        .set_mode  (set_q),
        .capture   (capture),
        .byte_wr   (byte_wr),
        .wdata     (bus_wdata),
        .shown     (shown),
        .staged    (staged),
        .hold_o    (hold_o),
        .osc_stop  (osc_stop),
        .freq_test (freq_test)
    );

    // Select the window byte addressed in this cycle.
    always_comb begin
        if (slot == '0) begin
            win_byte = {set_q, frz_q, spare_q};
        end else begin
            win_byte = shown[slot - 1'b1];
        end
    end

    // Register window read data and the source select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            sel_q <= 1'b0;
        end else begin
            rd_q  <= win_byte;
            sel_q <= win_hit;
        end
    end

    assign bus_rdata = sel_q ? rd_q : ram_rdata;
    assign ram_addr  = bus_addr;
    assign ram_wdata = bus_wdata;
    assign load_time = staged;

endmodule

// File: rtl/rtcw_window_chk.sv
// Module rtcw_window_chk
// Checker bound into rtcw_window. It relates the bus, the RAM strobe, the
// load strobe and the holding registers over time.
module rtcw_window_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              ram_we,
    input logic              load_stb,
    input logic              set_q,
    input logic              halted,
    input logic [55:0]       hold_flat
);

    localparam int unsigned       BASE_INT = (1 << ADDR_W) - 8;
    localparam logic [ADDR_W-1:0] WIN_BASE = BASE_INT[ADDR_W-1:0];

    // R1: window writes never reach the RAM
    a_r1_window_blocks_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr >= WIN_BASE) |-> !ram_we);

    // R1: writes below the window reach the RAM
    a_r1_low_reaches_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr < WIN_BASE) |-> ram_we);

    // R7: the load strobe lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    // R7: a load follows only the clearing of the set bit
    a_r7_load_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> ($past(set_q) && !set_q));

    // R4: held bytes stay put while halted and not written
    a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && $past(halted) && !$past(bus_we)) |-> $stable(hold_flat));

endmodule

bind rtcw_window rtcw_window_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .ram_we    (ram_we),
    .load_stb  (load_stb),
    .set_q     (set_q),
    .halted    (halted),
    .hold_flat (hold_flat)
);

// File: tb/sim_rtcw_window.sv
// Bench for rtcw_window. It mixes directed corner cases with seeded random
// traffic and checks against a reference model built from the requirements.
module sim_rtcw_window;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        ram_we;
    logic [12:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_q = '0;
    logic [6:0][7:0] live = '0;
    logic [55:0] live_time;
    logic        load_stb;
    logic [55:0] load_time;
    logic        osc_stop, freq_test;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic       m_set = 0, m_frz = 0;
    logic [5:0] m_spare = 0;
    logic [6:0][7:0] m_h;

    always #10 clk = ~clk;

    assign live_time = live;

    // external RAM stand-in with one cycle read latency
    always_ff @(posedge clk) ram_q <= ram_addr[7:0] ^ 8'h5A;

    rtcw_window u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_q),
        .live_time(live_time), .load_stb(load_stb), .load_time(load_time),
        .osc_stop(osc_stop), .freq_test(freq_test)
    );

    function automatic logic [7:0] fmask(input int p);
        case (p)
            0, 1:    return 8'h7F;
            2, 4:    return 8'h3F;
            3:       return 8'h07;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input int s);
        if (s == 0) return {m_set, m_frz, m_spare};
        if (m_set || m_frz) return m_h[s-1];
        return (live[s-1] & fmask(s-1)) | (m_h[s-1] & ~fmask(s-1));
    endfunction

    function automatic logic [55:0] exp_load();
        logic [55:0] v;
        for (int p = 0; p < 7; p++) v[p*8 +: 8] = m_h[p] & fmask(p);
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // window write with model update, RAM strobe and load checks
    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        logic want_load;
        want_load = 1'b0;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        #1;
        chk(a >= 13'h1FF8 ? "R1 ram_we window" : "R1 ram_we low", ram_we, a < 13'h1FF8);
        if (a >= 13'h1FF8) begin
            int s = int'(a[2:0]);
            if (s == 0) begin
                want_load = m_set && !d[7];
                if (!(m_set || m_frz) && (d[7] || d[6]))
                    for (int p = 0; p < 7; p++)
                        m_h[p] = (live[p] & fmask(p)) | (m_h[p] & ~fmask(p));
                m_set = d[7]; m_frz = d[6]; m_spare = d[5:0];
            end else begin
                m_h[s-1] = m_set ? d : ((m_h[s-1] & fmask(s-1)) | (d & ~fmask(s-1)));
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
        chk("R7 load strobe", load_stb, want_load);
        if (want_load) begin
            chk("R7 load value", load_time, exp_load());
            @(negedge clk);
            chk("R7 strobe drops", load_stb, 0);
        end
    endtask

    task automatic rd_chk(input string req, input logic [12:0] a);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        e = (a >= 13'h1FF8) ? exp_read(int'(a[2:0])) : (a[7:0] ^ 8'h5A);
        @(negedge clk);
        chk(req, bus_rdata, e);
    endtask

    task automatic set_live(input logic [55:0] v);
        @(negedge clk);
        live = v;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        m_h = '0;
        m_h[0] = 8'h80;
        live = 56'h24_12_31_05_23_59_58;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        chk("R2 osc_stop", osc_stop, 1);
        chk("R2 freq_test", freq_test, 0);
        chk("R2 load_stb", load_stb, 0);
        rd_chk("R2 control reset", 13'h1FF8);
        rd_chk("R2 seconds osc bit", 13'h1FF9);

        // R12 / R3 field masks on an all-ones live value
        set_live({7{8'hFF}});
        for (int s = 1; s < 8; s++) rd_chk("R12 field mask", 13'h1FF8 + 13'(s));
        set_live(56'h99_11_28_02_07_30_15);
        for (int s = 1; s < 8; s++) rd_chk("R3 live read", 13'h1FF8 + 13'(s));

        // R1 RAM pass-through and boundary
        wr(13'h0123, 8'h77);
        wr(13'h1FF7, 8'h11);
        rd_chk("R1 ram read", 13'h0042);
        rd_chk("R1 ram boundary", 13'h1FF7);

        // R8 / R10 field writes ignored, spare bit kept
        wr(13'h1FFA, 8'h80);
        rd_chk("R8 minutes ignored, R10 spare kept", 13'h1FFA);
        wr(13'h1FFA, 8'h00);

        // R4 freeze, R5 release
        wr(13'h1FF8, 8'h40);
        set_live(56'h00_01_01_01_00_00_01);
        rd_chk("R4 frozen seconds", 13'h1FF9);
        rd_chk("R4 frozen year", 13'h1FFF);
        wr(13'h1FF8, 8'h00);
        rd_chk("R5 live seconds", 13'h1FF9);

        // R6 stage, R7 commit
        wr(13'h1FF8, 8'h80);
        wr(13'h1FF9, 8'h25);
        wr(13'h1FFA, 8'h59);
        wr(13'h1FFF, 8'h31);
        set_live(56'h11_02_03_04_05_06_07);
        rd_chk("R6 staged seconds", 13'h1FF9);
        rd_chk("R6 staged year", 13'h1FFF);
        chk("R11 osc cleared by staged write", osc_stop, 0);
        wr(13'h1FF8, 8'h00);

        // R9 both bits set, set bit wins
        wr(13'h1FF8, 8'hC0);
        wr(13'h1FFB, 8'h13);
        wr(13'h1FF8, 8'h40);
        set_live(56'h22_03_04_05_06_07_08);
        rd_chk("R9 frozen after commit", 13'h1FFB);
        wr(13'h1FF8, 8'h00);

        // R10 control spare bits, R11 outputs
        wr(13'h1FF8, 8'h3F);
        rd_chk("R10 control spare", 13'h1FF8);
        rd_chk("R10 spare has no halt effect", 13'h1FF9);
        wr(13'h1FFC, 8'h40);
        chk("R11 freq_test", freq_test, 1);
        wr(13'h1FF9, 8'h80);
        chk("R11 osc_stop", osc_stop, 1);

        // random traffic
        for (int i = 0; i < 500; i++) begin
            int op = $urandom_range(0, 9);
            if (op < 2) begin
                set_live({$urandom, $urandom});
            end else if (op < 5) begin
                wr(13'h1FF8 + 13'($urandom_range(0, 7)), 8'($urandom));
            end else if (op < 8) begin
                rd_chk("R3 R4 R6 random read", 13'h1FF8 + 13'($urandom_range(0, 7)));
            end else if (op == 8) begin
                rd_chk("R1 random ram read", 13'($urandom_range(0, 8183)));
            end else begin
                wr(13'($urandom_range(0, 8183)), 8'($urandom));
            end
        end
        @(negedge clk);
        chk("R11 final osc_stop", osc_stop, m_h[0][7]);
        chk("R11 final freq_test", freq_test, m_h[3][6]);

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule